// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This unit sits beside one channel of a DMA engine and reduces the number of interrupts the processor has to take. It counts descriptor completions down from a programmable threshold, flagging an on-completion interrupt each time the count is used up. It also runs a delay timer that is restarted by every completion, so that a trickle of traffic too small to reach the threshold still produces a delay interrupt once the channel has gone quiet for the programmed number of ticks.

Both interrupt causes are held as sticky pending flags that software clears with write-one-to-clear strobes. A two-bit enable mask selects which pending causes drive the single interrupt line. The live counter and timer values are brought out for status readback. Threshold, delay and enable arrive as plain fields from a control register decoded elsewhere. The timer advances only on cycles where the single-cycle tick enable is high, so the tick rate is set by an external divider (for example 50 MHz) and the unit stays entirely in the system clock domain.

Top module: `dma_irq_coalesce`

## Requirements
- R1: While reset is asserted, both pending flags, the counter, the timer and the interrupt line are 0; reset acts asynchronously.
- R2: A reload pulse loads the counter from the threshold field on the next edge and takes priority over a completion in the same cycle (no on-completion event is then raised); it does not touch the timer.
- R3: A completion, with no reload, while the counter is above 1 lowers the counter by exactly one.
- R4: A completion, with no reload, while the counter is 1 or 0 sets the on-completion pending flag and reloads the counter from the threshold field (a threshold of 0 or 1 therefore fires on every completion).
- R5: A completion with a non-zero delay field loads the timer with the delay field, restarting it even when it is already running.
- R6: A completion with a delay field of 0 stops the timer at 0, and ticks do not move it afterwards.
- R7: A tick lowers a non-zero timer by one; without a tick, or with the timer at 0, the timer holds its value.
- R8: A tick with the timer at 1 and no completion sets the delay pending flag, reloads the counter from the threshold field and leaves the timer at 0; a completion in that same cycle restarts the timer instead and no delay event is raised.
- R9: Pending flags stay set until cleared; clear strobe bit 0 clears the on-completion flag and bit 1 the delay flag; a set and a clear of the same flag in one cycle leave it set.
- R10: The interrupt line is high exactly when the on-completion flag is set with enable bit 0 high, or the delay flag is set with enable bit 1 high; it follows an enable change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmpl_i | input | 1 | One-cycle pulse per completed descriptor |
| tick_i | input | 1 | One-cycle timer advance enable |
| reload_i | input | 1 | Channel start pulse, reloads the counter |
| thresh_i | input | THR_W | Completion threshold field |
| delay_i | input | DLY_W | Delay timer reload field |
| irq_en_i | input | 2 | Interrupt enables: bit 0 on-completion, bit 1 delay |
| clr_i | input | 2 | Write-one-to-clear strobes: bit 0 on-completion, bit 1 delay |
| ioc_pend_o | output | 1 | On-completion pending flag |
| dly_pend_o | output | 1 | Delay pending flag |
| cnt_o | output | THR_W | Live completion counter |
| tmr_o | output | DLY_W | Live delay timer |
| irq_o | output | 1 | Masked interrupt line |

## Verification
The counting path is driven with runs of completions against thresholds of 3, 5 and 0, which separates a plain decrement from the fire-and-reload step and shows that a zero threshold fires every time. The timer is driven with ticks interleaved with idle cycles and restarting completions, which distinguishes ticks from clock cycles and restart from continued countdown, and with a delay of 0 to show that the timer stays stopped. Collisions are exercised on purpose: completion with reload, completion with the final tick, and set with clear of the same flag, each of which exposes a wrong priority. The enable mask is switched with both flags set and with one set, which tells per-cause masking apart from a shared gate.

// File: rtl/dic_pkg.sv
package dic_pkg;
  // Interrupt cause indices shared by the flag bank, enables and clear strobes.
  localparam int NUM_SRC = 2;
  localparam int IOC_IDX = 0;
  localparam int DLY_IDX = 1;
endpackage

// File: rtl/dic_cmpl_counter.sv
module dic_cmpl_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmpl_i,
  input  logic         reload_i,
  input  logic         expire_i,
  input  logic [W-1:0] thresh_i,
  output logic [W-1:0] cnt_o,
  output logic         fire_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         cnt_en;

  // Threshold used up: the event is raised and the count starts over.
  assign fire_o = cmpl_i & ~reload_i & (cnt_q <= ONE);
  assign cnt_en = reload_i | cmpl_i | expire_i;

  always_comb begin
    cnt_nxt = cnt_q;
    if (reload_i || fire_o || expire_i) begin
      cnt_nxt = thresh_i;
    end else if (cmpl_i) begin
      cnt_nxt = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dic_delay_timer.sv
module dic_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmpl_i,
  input  logic         tick_i,
  input  logic [W-1:0] delay_i,
  output logic [W-1:0] tmr_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] tmr_q, tmr_nxt;
  logic         running;
  logic         tmr_en;

  // A non-zero value means the timer is counting.
  assign running  = (tmr_q != '0);
  assign expire_o = tick_i & ~cmpl_i & (tmr_q == ONE);
  assign tmr_en   = cmpl_i | (tick_i & running);

  always_comb begin
    tmr_nxt = tmr_q;
    if (cmpl_i) begin
      tmr_nxt = delay_i;  // zero delay leaves the timer stopped
    end else if (tick_i && running) begin
      tmr_nxt = tmr_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_nxt;
    end
  end

  assign tmr_o = tmr_q;
endmodule

// File: rtl/dic_pend_flags.sv
module dic_pend_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, pend_nxt;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // Set beats clear when both land in the same cycle.
    always_comb begin
      pend_nxt[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g] <= 1'b0;
      end else if (set_i[g] || clr_i[g]) begin
        pend_q[g] <= pend_nxt[g];
      end
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
  import dic_pkg::*;
#(
  parameter int THR_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmpl_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [1:0]       irq_en_i,
  input  logic [1:0]       clr_i,
  output logic             ioc_pend_o,
  output logic             dly_pend_o,
  output logic [THR_W-1:0] cnt_o,
  output logic [DLY_W-1:0] tmr_o,
  output logic             irq_o
);
  logic               fire;
  logic               expire;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] pend_vec;

  dic_cmpl_counter #(.W(THR_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmpl_i   (cmpl_i),
    .reload_i (reload_i),
    .expire_i (expire),
    .thresh_i (thresh_i),
    .cnt_o    (cnt_o),
    .fire_o   (fire)
  );

  dic_delay_timer #(.W(DLY_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmpl_i   (cmpl_i),
    .tick_i   (tick_i),
    .delay_i  (delay_i),
    .tmr_o    (tmr_o),
    .expire_o (expire)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IOC_IDX] = fire;
    set_vec[DLY_IDX] = expire;
  end

  dic_pend_flags #(.N(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_i),
    .en_i   (irq_en_i),
    .pend_o (pend_vec),
    .irq_o  (irq_o)
  );

  assign ioc_pend_o = pend_vec[IOC_IDX];
  assign dly_pend_o = pend_vec[DLY_IDX];
endmodule

// File: rtl/dma_irq_coalesce_chk.sv
module dma_irq_coalesce_chk #(
  parameter int THR_W = 8,
  parameter int DLY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmpl_i,
  input logic             tick_i,
  input logic             reload_i,
  input logic [THR_W-1:0] thresh_i,
  input logic [DLY_W-1:0] delay_i,
  input logic [1:0]       irq_en_i,
  input logic [1:0]       clr_i,
  input logic             ioc_pend_o,
  input logic             dly_pend_o,
  input logic [THR_W-1:0] cnt_o,
  input logic [DLY_W-1:0] tmr_o,
  input logic             irq_o
);
  AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_o == $past(thresh_i))); // R2
  AST_CMPL_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && !reload_i && cnt_o > THR_W'(1)) |=> (cnt_o == $past(cnt_o) - THR_W'(1))); // R3
  AST_IOC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && !reload_i && cnt_o <= THR_W'(1)) |=> (ioc_pend_o && cnt_o == $past(thresh_i))); // R4
  AST_TMR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && delay_i != '0) |=> (tmr_o == $past(delay_i))); // R5
  AST_TMR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && delay_i == '0) |=> (tmr_o == '0)); // R6
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmpl_i && (!tick_i || tmr_o == '0)) |=> $stable(tmr_o)); // R7
  AST_DLY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmpl_i && tick_i && tmr_o == DLY_W'(1)) |=> (dly_pend_o && tmr_o == '0)); // R8
  AST_IOC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ioc_pend_o && !clr_i[0]) |=> ioc_pend_o); // R9
  AST_DLY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_pend_o && !clr_i[1]) |=> dly_pend_o); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ioc_pend_o && !dly_pend_o) |-> !irq_o); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == 2'b00) |-> !irq_o); // R10
endmodule

bind dma_irq_coalesce dma_irq_coalesce_chk #(.THR_W(THR_W), .DLY_W(DLY_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmpl_i     (cmpl_i),
  .tick_i     (tick_i),
  .reload_i   (reload_i),
  .thresh_i   (thresh_i),
  .delay_i    (delay_i),
  .irq_en_i   (irq_en_i),
  .clr_i      (clr_i),
  .ioc_pend_o (ioc_pend_o),
  .dly_pend_o (dly_pend_o),
  .cnt_o      (cnt_o),
  .tmr_o      (tmr_o),
  .irq_o      (irq_o)
);

// File: tb/dma_irq_coalesce_tb_top.sv
module dma_irq_coalesce_tb_top;
  typedef struct packed {
    logic       cmpl;
    logic       tick;
    logic       rld;
    logic [1:0] clr;
    logic [7:0] th;
    logic [7:0] dl;
    logic [1:0] en;
    logic       e_ioc;
    logic       e_dly;
    logic [7:0] e_cnt;
    logic [7:0] e_tmr;
    logic       e_irq;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 31;
  // cmpl tick rld clr th dl en | ioc dly cnt tmr irq | req
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd3,8'd0,1'b0, 4'd2},  // R2 load 3
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd4,1'b0, 4'd3},  // R3 3->2, timer 4
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd3,1'b0, 4'd7},  // R7 tick
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd1,8'd4,1'b0, 4'd5},  // R5 restart
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b1,1'b0,8'd3,8'd4,1'b1, 4'd4},  // R4 fire
    '{1'b0,1'b0,1'b0,2'b01,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd3,8'd4,1'b0, 4'd9},  // R9 clear ioc
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd4,1'b0, 4'd3},  // R3
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd3,1'b0, 4'd7},  // R7
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd2,1'b0, 4'd7},  // R7
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd1,1'b0, 4'd7},  // R7
    '{1'b0,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd1,1'b0, 4'd7},  // R7 no tick holds
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b1,8'd3,8'd0,1'b1, 4'd8},  // R8 expire
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b1,8'd3,8'd0,1'b1, 4'd7},  // R7 zero ignores tick
    '{1'b0,1'b0,1'b0,2'b00,8'd3,8'd4,2'b01, 1'b0,1'b1,8'd3,8'd0,1'b0, 4'd10}, // R10 dly masked
    '{1'b0,1'b0,1'b0,2'b10,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd3,8'd0,1'b0, 4'd9},  // R9 clear dly
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd2,8'd4,1'b0, 4'd3},  // R3
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b0,1'b0,8'd1,8'd4,1'b0, 4'd3},  // R3
    '{1'b1,1'b0,1'b0,2'b01,8'd3,8'd4,2'b11, 1'b1,1'b0,8'd3,8'd4,1'b1, 4'd9},  // R9 set wins
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd0,2'b11, 1'b1,1'b0,8'd2,8'd0,1'b1, 4'd6},  // R6 stop
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd0,2'b11, 1'b1,1'b0,8'd2,8'd0,1'b1, 4'd6},  // R6 stays
    '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b1,1'b0,8'd1,8'd4,1'b1, 4'd5},  // R5
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b1,1'b0,8'd1,8'd3,1'b1, 4'd7},  // R7
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b1,1'b0,8'd1,8'd2,1'b1, 4'd7},  // R7
    '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b1,1'b0,8'd1,8'd1,1'b1, 4'd7},  // R7
    '{1'b1,1'b1,1'b0,2'b00,8'd3,8'd4,2'b11, 1'b1,1'b0,8'd3,8'd4,1'b1, 4'd8},  // R8 cmpl beats expiry
    '{1'b0,1'b0,1'b1,2'b00,8'd5,8'd4,2'b11, 1'b1,1'b0,8'd5,8'd4,1'b1, 4'd2},  // R2 timer untouched
    '{1'b1,1'b0,1'b1,2'b00,8'd5,8'd6,2'b11, 1'b1,1'b0,8'd5,8'd6,1'b1, 4'd2},  // R2 reload beats cmpl
    '{1'b0,1'b0,1'b1,2'b01,8'd0,8'd6,2'b11, 1'b0,1'b0,8'd0,8'd6,1'b0, 4'd2},  // R2 load 0
    '{1'b1,1'b0,1'b0,2'b00,8'd0,8'd6,2'b11, 1'b1,1'b0,8'd0,8'd6,1'b1, 4'd4},  // R4 zero threshold
    '{1'b0,1'b0,1'b0,2'b00,8'd0,8'd6,2'b00, 1'b1,1'b0,8'd0,8'd6,1'b0, 4'd10}, // R10 all masked
    '{1'b0,1'b1,1'b0,2'b00,8'd0,8'd6,2'b10, 1'b1,1'b0,8'd0,8'd5,1'b0, 4'd10}  // R10 ioc masked
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cmpl_i, tick_i, reload_i;
  logic [7:0] thresh_i, delay_i;
  logic [1:0] irq_en_i, clr_i;
  logic       ioc_pend_o, dly_pend_o, irq_o;
  logic [7:0] cnt_o, tmr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dma_irq_coalesce #(.THR_W(8), .DLY_W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmpl_i(cmpl_i), .tick_i(tick_i),
    .reload_i(reload_i), .thresh_i(thresh_i), .delay_i(delay_i),
    .irq_en_i(irq_en_i), .clr_i(clr_i), .ioc_pend_o(ioc_pend_o),
    .dly_pend_o(dly_pend_o), .cnt_o(cnt_o), .tmr_o(tmr_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic e_ioc, input logic e_dly,
                       input logic [7:0] e_cnt, input logic [7:0] e_tmr, input logic e_irq);
    n_chk++;
    if (ioc_pend_o !== e_ioc || dly_pend_o !== e_dly || cnt_o !== e_cnt ||
        tmr_o !== e_tmr || irq_o !== e_irq) begin
      n_fail++;
      $display("FAIL %s: got ioc=%b dly=%b cnt=%0d tmr=%0d irq=%b, expected ioc=%b dly=%b cnt=%0d tmr=%0d irq=%b",
               req, ioc_pend_o, dly_pend_o, cnt_o, tmr_o, irq_o, e_ioc, e_dly, e_cnt, e_tmr, e_irq);
    end
  endtask

  task automatic idle_inputs();
    cmpl_i = 1'b0; tick_i = 1'b0; reload_i = 1'b0; clr_i = 2'b00;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    idle_inputs();
    thresh_i = 8'd3; delay_i = 8'd4; irq_en_i = 2'b11;
    repeat (3) @(negedge clk_i);
    check("R1 reset state", 1'b0, 1'b0, 8'd0, 8'd0, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cmpl_i = VEC[i].cmpl; tick_i = VEC[i].tick; reload_i = VEC[i].rld;
      clr_i = VEC[i].clr; thresh_i = VEC[i].th; delay_i = VEC[i].dl;
      irq_en_i = VEC[i].en;
      @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].e_ioc, VEC[i].e_dly,
            VEC[i].e_cnt, VEC[i].e_tmr, VEC[i].e_irq);
    end

    // Directed: mid-run reset clears everything without a clock edge (R1).
    idle_inputs();
    irq_en_i = 2'b11;
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1 async reset", 1'b0, 1'b0, 8'd0, 8'd0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // Directed: threshold 1 fires on every completion (R4).
    thresh_i = 8'd1; delay_i = 8'd2; reload_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    reload_i = 1'b0; cmpl_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check("R4 threshold one", 1'b1, 1'b0, 8'd1, 8'd2, 1'b1);
    clr_i = 2'b01;
    @(posedge clk_i); @(negedge clk_i);
    check("R4 threshold one again", 1'b1, 1'b0, 8'd1, 8'd2, 1'b1);

    // Directed: two ticks with delay 2 raise the delay flag (R8).
    cmpl_i = 1'b0; clr_i = 2'b01; tick_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check("R8 countdown", 1'b0, 1'b0, 8'd1, 8'd1, 1'b0);
    clr_i = 2'b00;
    @(posedge clk_i); @(negedge clk_i);
    check("R8 delay expiry", 1'b0, 1'b1, 8'd1, 8'd0, 1'b1);
    idle_inputs();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule